// File: doc/BRIEF.md
# Clock Source Mode Controller

This block decides which of three clock sources drives the system: the main oscillator divided by two, a multiplied clock from a PLL, or a slow sub-clock. Software writes a small control word holding two active-low request bits (one asking for the PLL, one asking for the sub-clock), a two-bit selector for the main-oscillator stabilization wait, and a multiplier field that is passed straight to the PLL. The block turns those requests into a source-select code for an external glitch-free clock multiplexer, and into enables for the PLL and the main oscillator.

Each direction of change has its own completion rule. Moving from main to PLL turns the PLL on and waits a fixed stabilization count. Moving from PLL back to main waits until the external logic reports that the PLL and main clock edges line up. Moving from main to sub-clock waits for a number of sub-clock ticks so the switch is synchronized. Moving from sub-clock back to main turns the oscillator on and waits a stabilization count picked by the selector. The block evaluates requests only in a settled mode, so a request written during a change stays pending until that change completes. The PLL and the sub-clock never hand over directly; any path between them passes through main mode.

The select output tells software which source is really active. A separate busy flag shows that a change is in progress, so software can poll for completion. The whole block runs in the main clock domain. Every wait is counted in its cycles, and the sub-clock arrives as a tick pulse already in that domain.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the block is in main mode: `clk_sel` is 0 (main), `osc_en` is 1, `pll_en` is 0 and `switching` is 0. The read-back fields read `rd_pll_off`=1, `rd_sub_off`=1, `rd_wait_sel`=0 and `pll_mult`=0. While both request bits stay 1, edge-match and tick pulses do not move the block out of main mode.
- R2: A cycle with `cfg_we`=1 stores all four fields at that clock edge. They read back on the next cycle, and `pll_mult` drives the stored multiplier to the PLL.
- R3: In main mode, writing `cfg_pll_off`=0 (with `cfg_sub_off`=1) raises `pll_en` one cycle after the write edge while `clk_sel` stays 0. `clk_sel` becomes 1 (PLL) exactly 2^PLL_WAIT_LOG2 cycles after `pll_en` rose.
- R4: In PLL mode, writing `cfg_pll_off`=1 keeps `clk_sel`=1 for as long as `edge_match` is low. At the first clock edge that samples `edge_match` high, `clk_sel` goes to 0 and `pll_en` falls.
- R5: In main mode, writing `cfg_sub_off`=0 keeps `clk_sel`=0 until SUB_SYNC_TICKS `sub_tick` pulses have been sampled. At the edge that samples the last of these pulses, `clk_sel` becomes 2 (sub) and `osc_en` and `pll_en` are both 0.
- R6: In sub mode, writing `cfg_sub_off`=1 raises `osc_en` one cycle after the write edge. `clk_sel` goes to 0 exactly 2^E cycles later. E is OSC_WAIT_LOG2_0, _1, _2 or _3 for `rd_wait_sel` codes 0, 1, 2 or 3, sampled when the wait starts.
- R7: A write made while a change is in progress does not alter or shorten that change. The new request is acted on in the cycle after the change completes.
- R8: `switching` is 1 in every cycle from the edge that starts a change up to the edge that completes it, and 0 in settled modes.
- R9: From main mode with both request bits 0, the sub-clock request wins and the PLL stays off. A sub-clock request made in PLL mode first returns to main through the edge-match rule, then enters the sub-clock through the tick rule.
- R10: `clk_sel` never takes code 3, and it never moves directly between 1 (PLL) and 2 (sub) in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_pll_off | input | 1 | Written PLL request bit, 0 asks for the PLL |
| cfg_sub_off | input | 1 | Written sub-clock request bit, 0 asks for the sub-clock |
| cfg_wait_sel | input | 2 | Written oscillator wait selector |
| cfg_mult | input | MULT_W | Written PLL multiplier |
| edge_match | input | 1 | PLL and main clock edges coincide this cycle |
| sub_tick | input | 1 | One-cycle pulse per sub-clock period |
| rd_pll_off | output | 1 | Stored PLL request bit |
| rd_sub_off | output | 1 | Stored sub-clock request bit |
| rd_wait_sel | output | 2 | Stored wait selector |
| pll_mult | output | MULT_W | Multiplier driven to the PLL |
| clk_sel | output | 2 | Active source: 0 main, 1 PLL, 2 sub |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Main oscillator enable |
| switching | output | 1 | A mode change is in progress |

## Verification
A control write lands at the clock edge of the write cycle, and the block's enables react one edge later. `clk_sel` then follows after exactly the wait length for timed changes, or at the very edge that samples the qualifying `edge_match` or final `sub_tick`. The bench drives and samples on falling edges. It counts the cycles from a write until `clk_sel` reaches the target, and compares that count with 2^E for each wait code from a table, and with the fixed PLL wait. For the event-driven changes it checks that the select has not moved one pulse before the qualifying event and has moved right after it. Writes made during a change are placed at known cycles, so the completion cycle of the in-flight change can still be predicted exactly.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_SUB  = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        ST_MAIN,
        ST_PLL_WAIT,
        ST_PLL,
        ST_PLL_EXIT,
        ST_SUB_ENTER,
        ST_SUB,
        ST_OSC_WAIT
    } mode_st_e;

    typedef struct packed {
        src_e src;
        logic pll_on;
        logic osc_on;
        logic busy;
    } drive_t;

    typedef struct packed {
        logic       pll_off;
        logic       sub_off;
        logic [1:0] wait_sel;
    } mode_cfg_t;

    function automatic drive_t state_drive(mode_st_e s);
        drive_t d;
        d = '{src: SRC_MAIN, pll_on: 1'b0, osc_on: 1'b1, busy: 1'b0};
        case (s)
            ST_MAIN:      d = '{src: SRC_MAIN, pll_on: 1'b0, osc_on: 1'b1, busy: 1'b0};
            ST_PLL_WAIT:  d = '{src: SRC_MAIN, pll_on: 1'b1, osc_on: 1'b1, busy: 1'b1};
            ST_PLL:       d = '{src: SRC_PLL,  pll_on: 1'b1, osc_on: 1'b1, busy: 1'b0};
            ST_PLL_EXIT:  d = '{src: SRC_PLL,  pll_on: 1'b1, osc_on: 1'b1, busy: 1'b1};
            ST_SUB_ENTER: d = '{src: SRC_MAIN, pll_on: 1'b0, osc_on: 1'b1, busy: 1'b1};
            ST_SUB:       d = '{src: SRC_SUB,  pll_on: 1'b0, osc_on: 1'b0, busy: 1'b0};
            ST_OSC_WAIT:  d = '{src: SRC_SUB,  pll_on: 1'b0, osc_on: 1'b1, busy: 1'b1};
            default:      d = '{src: SRC_MAIN, pll_on: 1'b0, osc_on: 1'b1, busy: 1'b0};
        endcase
        return d;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cmc_cfg_reg.sv
module cmc_cfg_reg
    import cmc_pkg::*;
#(
    parameter int MULT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  mode_cfg_t         cfg_d,
    input  logic [MULT_W-1:0] mult_d,
    output mode_cfg_t         cfg_q,
    output logic [MULT_W-1:0] mult_q
);

    localparam mode_cfg_t CFG_RST = '{pll_off: 1'b1, sub_off: 1'b1, wait_sel: 2'd0};

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RST;
            mult_q  <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (we) begin
                cfg_q  <= cfg_d;
                mult_q <= mult_d;
            end
        end
    end

    // R2: stored fields change only through a write strobe
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(we)) |-> ($stable(cfg_q) && $stable(mult_q)));

endmodule

// File: rtl/cmc_wait_timer.sv
module cmc_wait_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             done
);

    logic [CNT_W-1:0] cnt;
    logic             run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= load;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);

    // R3 / R6: a started wait holds its loaded length
    p_timer_load_r6: assert property (@(posedge clk) disable iff (rst)
        start |=> (run && cnt == $past(load)));

    // R6: the counter only moves downward while running
    p_timer_down_r6: assert property (@(posedge clk) disable iff (rst)
        (run && !start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/cmc_sub_sync.sv
module cmc_sub_sync #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    output logic done
);

    localparam int TW = $clog2(TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)   cnt <= '0;
        else if (tick && cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = en && tick && (cnt == LAST);

    // R5: the tick count never runs past the sync length
    p_sync_bound_r5: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt <= LAST));

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
    import cmc_pkg::*;
#(
    parameter int MULT_W          = 3,
    parameter int PLL_WAIT_LOG2   = 14,
    parameter int OSC_WAIT_LOG2_0 = 10,
    parameter int OSC_WAIT_LOG2_1 = 13,
    parameter int OSC_WAIT_LOG2_2 = 15,
    parameter int OSC_WAIT_LOG2_3 = 17,
    parameter int SUB_SYNC_TICKS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_pll_off,
    input  logic              cfg_sub_off,
    input  logic [1:0]        cfg_wait_sel,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic              edge_match,
    input  logic              sub_tick,
    output logic              rd_pll_off,
    output logic              rd_sub_off,
    output logic [1:0]        rd_wait_sel,
    output logic [MULT_W-1:0] pll_mult,
    output logic [1:0]        clk_sel,
    output logic              pll_en,
    output logic              osc_en,
    output logic              switching
);

    localparam int OSC_LOG2 [4] = '{OSC_WAIT_LOG2_0, OSC_WAIT_LOG2_1,
                                    OSC_WAIT_LOG2_2, OSC_WAIT_LOG2_3};
    localparam int CNT_W = max_of(PLL_WAIT_LOG2,
                           max_of(max_of(OSC_WAIT_LOG2_0, OSC_WAIT_LOG2_1),
                                  max_of(OSC_WAIT_LOG2_2, OSC_WAIT_LOG2_3)));
    localparam logic [CNT_W-1:0] ONES     = '1;
    localparam logic [CNT_W-1:0] PLL_LOAD = ONES >> (CNT_W - PLL_WAIT_LOG2);

    mode_cfg_t        cfg_d, cfg_q;
    mode_st_e         state, state_nx;
    drive_t           drv;
    logic [CNT_W-1:0] osc_load [4];
    logic [CNT_W-1:0] tmr_load;
    logic             start_pll, start_osc, tmr_done, sync_done;
    logic             past_ok;

    genvar g;
    generate
        for (g = 0; g < 4; g++) begin : g_osc_len
            assign osc_load[g] = ONES >> (CNT_W - OSC_LOG2[g]);
        end
    endgenerate

    assign cfg_d = '{pll_off: cfg_pll_off, sub_off: cfg_sub_off, wait_sel: cfg_wait_sel};

    cmc_cfg_reg #(.MULT_W(MULT_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .cfg_d  (cfg_d),
        .mult_d (cfg_mult),
        .cfg_q  (cfg_q),
        .mult_q (pll_mult)
    );

    always_comb begin
        state_nx = state;
        case (state)
            ST_MAIN: begin
                if (!cfg_q.sub_off)      state_nx = ST_SUB_ENTER;
                else if (!cfg_q.pll_off) state_nx = ST_PLL_WAIT;
            end
            ST_PLL_WAIT:  if (tmr_done)   state_nx = ST_PLL;
            ST_PLL:       if (cfg_q.pll_off || !cfg_q.sub_off) state_nx = ST_PLL_EXIT;
            ST_PLL_EXIT:  if (edge_match) state_nx = ST_MAIN;
            ST_SUB_ENTER: if (sync_done)  state_nx = ST_SUB;
            ST_SUB:       if (cfg_q.sub_off) state_nx = ST_OSC_WAIT;
            ST_OSC_WAIT:  if (tmr_done)   state_nx = ST_MAIN;
            default:      state_nx = ST_MAIN;
        endcase
    end

    assign start_pll = (state == ST_MAIN) && (state_nx == ST_PLL_WAIT);
    assign start_osc = (state == ST_SUB)  && (state_nx == ST_OSC_WAIT);
    assign tmr_load  = start_pll ? PLL_LOAD : osc_load[cfg_q.wait_sel];

    cmc_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start_pll || start_osc),
        .load  (tmr_load),
        .done  (tmr_done)
    );

    cmc_sub_sync #(.TICKS(SUB_SYNC_TICKS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .en   (state == ST_SUB_ENTER),
        .tick (sub_tick),
        .done (sync_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_MAIN;
            past_ok <= 1'b0;
        end else begin
            state   <= state_nx;
            past_ok <= 1'b1;
        end
    end

    assign drv         = state_drive(state);
    assign clk_sel     = drv.src;
    assign pll_en      = drv.pll_on;
    assign osc_en      = drv.osc_on;
    assign switching   = drv.busy;
    assign rd_pll_off  = cfg_q.pll_off;
    assign rd_sub_off  = cfg_q.sub_off;
    assign rd_wait_sel = cfg_q.wait_sel;

    // R10: the select code stays within the three sources
    p_sel_legal_r10: assert property (@(posedge clk) disable iff (rst)
        clk_sel != 2'd3);

    // R10: no direct hand-over between PLL and sub-clock
    p_no_hop_r10: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> !((clk_sel == SRC_SUB && $past(clk_sel) == SRC_PLL) ||
                      (clk_sel == SRC_PLL && $past(clk_sel) == SRC_SUB)));

    // R3: the PLL is selected only on a finished stabilization count
    p_pll_after_wait_r3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && clk_sel == SRC_PLL && $past(clk_sel) == SRC_MAIN) |-> $past(tmr_done));

    // R4: leaving the PLL needs a sampled edge coincidence
    p_main_after_match_r4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && clk_sel == SRC_MAIN && $past(clk_sel) == SRC_PLL) |-> $past(edge_match));

    // R5: sub mode settled means both fast sources are off
    p_sub_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == SRC_SUB && !switching) |-> (!osc_en && !pll_en));

    // R6: the main clock is selected only with its oscillator running
    p_main_osc_r6: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == SRC_MAIN) |-> osc_en);

    // R8: in a settled mode the PLL runs exactly when it is the source
    p_settled_pll_r8: assert property (@(posedge clk) disable iff (rst)
        !switching |-> (pll_en == (clk_sel == SRC_PLL)));

endmodule

// File: tb/sim_clk_mode_ctrl.sv
module sim_clk_mode_ctrl;

    localparam int MW = 2;
    localparam int PLL_N = 32;
    localparam int TICKS = 3;
    localparam int VEC_CODE [4] = '{0, 1, 2, 3};
    localparam int VEC_LAT  [4] = '{8, 16, 32, 64};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0, cfg_pll_off = 1'b1, cfg_sub_off = 1'b1;
    logic [1:0]    cfg_wait_sel = 2'd0;
    logic [MW-1:0] cfg_mult = '0;
    logic          edge_match = 1'b0, sub_tick = 1'b0;
    logic          rd_pll_off, rd_sub_off, pll_en, osc_en, switching;
    logic [1:0]    rd_wait_sel, clk_sel;
    logic [MW-1:0] pll_mult;

    int total = 0;
    int bad   = 0;
    int illegal = 0;
    logic [1:0] prev_sel = 2'd0;

    logic          sh_pll_off = 1'b1, sh_sub_off = 1'b1;
    logic [1:0]    sh_wait = 2'd0;
    logic [MW-1:0] sh_mult = '0;

    always #4 clk = ~clk;

    clk_mode_ctrl #(
        .MULT_W(MW), .PLL_WAIT_LOG2(5),
        .OSC_WAIT_LOG2_0(3), .OSC_WAIT_LOG2_1(4),
        .OSC_WAIT_LOG2_2(5), .OSC_WAIT_LOG2_3(6),
        .SUB_SYNC_TICKS(TICKS)
    ) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_pll_off(cfg_pll_off),
        .cfg_sub_off(cfg_sub_off), .cfg_wait_sel(cfg_wait_sel), .cfg_mult(cfg_mult),
        .edge_match(edge_match), .sub_tick(sub_tick), .rd_pll_off(rd_pll_off),
        .rd_sub_off(rd_sub_off), .rd_wait_sel(rd_wait_sel), .pll_mult(pll_mult),
        .clk_sel(clk_sel), .pll_en(pll_en), .osc_en(osc_en), .switching(switching)
    );

    // R10 monitor: illegal codes and direct PLL/sub hops
    always @(negedge clk) begin
        if (!rst) begin
            if (clk_sel == 2'd3) illegal++;
            if ((prev_sel == 2'd1 && clk_sel == 2'd2) ||
                (prev_sel == 2'd2 && clk_sel == 2'd1)) illegal++;
            prev_sel = clk_sel;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr();
        cfg_we = 1'b1; cfg_pll_off = sh_pll_off; cfg_sub_off = sh_sub_off;
        cfg_wait_sel = sh_wait; cfg_mult = sh_mult;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_tick();
        sub_tick = 1'b1;
        @(negedge clk);
        sub_tick = 1'b0;
    endtask

    task automatic pulse_match();
        edge_match = 1'b1;
        @(negedge clk);
        edge_match = 1'b0;
    endtask

    task automatic run_until(input logic [1:0] tgt, inout int n);
        while (clk_sel !== tgt && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic enter_sub();
        sh_sub_off = 1'b0; wr(); step();
        for (int k = 0; k < TICKS; k++) begin
            pulse_tick();
            step();
        end
    endtask

    initial begin
        #(8 * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (4) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 clk_sel", clk_sel, 0);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 pll_en", pll_en, 0);
        chk("R1 switching", switching, 0);
        chk("R1 rd_pll_off", rd_pll_off, 1);
        chk("R1 rd_sub_off", rd_sub_off, 1);
        chk("R1 rd_wait_sel", rd_wait_sel, 0);
        chk("R1 pll_mult", pll_mult, 0);
        pulse_match(); pulse_tick(); step();
        chk("R1 idle main", clk_sel, 0);
        chk("R1 idle busy", switching, 0);

        // R2 register write and pass-through
        sh_mult = 2'd2; sh_wait = 2'd2; wr();
        chk("R2 pll_mult", pll_mult, 2);
        chk("R2 rd_wait_sel", rd_wait_sel, 2);
        chk("R2 still main", clk_sel, 0);

        // R3 main to PLL
        sh_pll_off = 1'b0; wr();
        chk("R3 pll_en before", pll_en, 0);
        step();
        chk("R3 pll_en rise", pll_en, 1);
        chk("R3 sel during wait", clk_sel, 0);
        chk("R8 busy in wait", switching, 1);
        n = 0; run_until(2'd1, n);
        chk("R3 wait length", n, PLL_N);
        chk("R8 settled pll", switching, 0);

        // R4 PLL to main via edge coincidence
        sh_pll_off = 1'b1; wr(); step();
        chk("R4 still pll", clk_sel, 1);
        chk("R8 busy exit", switching, 1);
        repeat (3) step();
        chk("R4 waits match", clk_sel, 1);
        pulse_match();
        chk("R4 main after match", clk_sel, 0);
        chk("R4 pll off", pll_en, 0);
        chk("R8 settled main", switching, 0);

        // R5 main to sub
        sh_sub_off = 1'b0; wr(); step();
        chk("R5 sync main", clk_sel, 0);
        chk("R8 busy sync", switching, 1);
        pulse_tick(); step(); pulse_tick(); step();
        chk("R5 before last tick", clk_sel, 0);
        pulse_tick();
        chk("R5 sub entered", clk_sel, 2);
        chk("R5 osc off", osc_en, 0);
        chk("R5 pll off", pll_en, 0);

        // R6 table of wait codes: sub to main
        for (int i = 0; i < 4; i++) begin
            sh_wait = VEC_CODE[i][1:0]; sh_sub_off = 1'b1; wr();
            step();
            chk("R6 osc_en rise", osc_en, 1);
            chk("R6 sel sub in wait", clk_sel, 2);
            n = 0; run_until(2'd0, n);
            chk("R6 wait length", n, VEC_LAT[i]);
            if (i < 3) begin
                enter_sub();
                chk("R6 back in sub", clk_sel, 2);
            end
        end

        // R7 pending write during the PLL wait
        sh_pll_off = 1'b0; wr();
        n = 0;
        repeat (3) begin step(); n++; end
        sh_pll_off = 1'b1; wr(); n++;
        run_until(2'd1, n);
        chk("R7 wait not shortened", n, PLL_N + 1);
        step();
        chk("R7 pending exit", switching, 1);
        chk("R7 pending sel", clk_sel, 1);
        pulse_match();
        chk("R7 back to main", clk_sel, 0);

        // R7 pending write during sub sync
        sh_sub_off = 1'b0; wr(); step();
        pulse_tick();
        sh_sub_off = 1'b1; wr();
        pulse_tick(); pulse_tick();
        chk("R7 sync completes", clk_sel, 2);
        n = 0; run_until(2'd0, n);
        chk("R7 pending return", n, 65);

        // R9 sub wins over PLL; PLL exit on sub request goes through main
        sh_pll_off = 1'b0; sh_sub_off = 1'b0; wr(); step();
        chk("R9 pll stays off", pll_en, 0);
        chk("R9 sync busy", switching, 1);
        for (int k = 0; k < TICKS; k++) pulse_tick();
        chk("R9 sub first", clk_sel, 2);
        sh_sub_off = 1'b1; wr();
        n = 0; run_until(2'd0, n);
        n = 0; run_until(2'd1, n);
        chk("R9 pll after main", n, PLL_N + 1);
        sh_sub_off = 1'b0; wr(); step();
        chk("R9 exit pending", clk_sel, 1);
        pulse_match();
        chk("R9 via main", clk_sel, 0);
        step();
        chk("R9 sync after exit", switching, 1);
        chk("R9 pll off in sync", pll_en, 0);
        for (int k = 0; k < TICKS; k++) pulse_tick();
        chk("R9 sub reached", clk_sel, 2);
        sh_pll_off = 1'b1; sh_sub_off = 1'b1; wr();
        n = 0; run_until(2'd0, n);
        chk("R9 restored main", clk_sel, 0);

        chk("R10 no illegal select or hop", illegal, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule